// File: doc/BRIEF.md
# Segment Node Assignment Router

This block is one stage in a series chain of routers, each of which serves its own group of filter nodes. Event tags arrive on a valid/ready input. Each tag carries an event type and an event number, and it may ask for a duplicate (shadow) copy. For every tag, the router decides whether one of its own nodes can take the event. It bases that decision on a programmable table, which lists the event types each node accepts, and on a live ready flag for each node. When the router claims a tag, it picks a node by round-robin. For a shadow request it picks a second, different node. It records the assignment and marks the tag as taken. Every tag, claimed or not, is then forwarded unchanged to the next stage, apart from the taken mark.

Data blocks for many events can arrive interleaved. Each block names its event in its header. The router looks up that event in a small assignment table and presents the block to the assigned node or nodes. A block flagged as the last one of its event releases the table entry. A block whose event has no entry is dropped and counted. It is never resent.

Top module: `snr_segment_router`

## Requirements
- R1: After reset, tag_out_valid, node_out_valid, node_avail and drop_count are all zero. The round-robin pointer is set so that the first choice searches from node 0.
- R2: A node can be chosen for a tag only if its ready flag is set and bit t of its type mask is set, where t is the tag's type. A write with cfg_we loads cfg_types as the mask of node cfg_node.
- R3: The primary node is the first candidate at or after the node following the last primary choice, wrapping from NODES-1 to 0.
- R4: Assigning a node clears its ready flag. A pulse on node_ready_set sets the flag again. If a set pulse arrives in the same cycle that node is assigned, the set is ignored.
- R5: A tag with tag_in_shadow=1 is claimed for two distinct nodes. The primary is chosen as in R3. The shadow is the next candidate after the primary. If fewer than two candidates exist, the tag is declined and no flag changes.
- R6: Each accepted tag appears on the tag output in the next cycle with the same type, event number and shadow bit. Its taken bit is the input taken bit OR'd with this stage's claim.
- R7: A tag that arrives already taken causes no assignment. The node_avail flags and the assignment table are left unchanged.
- R8: A data block whose event number has a table entry is presented in the next cycle on node_out_data, with node_out_valid equal to the assigned node mask.
- R9: Routing a block with blk_last=1 frees its entry. Later blocks of that event are dropped.
- R10: A block with no matching entry produces node_out_valid=0 and increases drop_count by one. The count saturates at all ones.
- R11: When all DEPTH table entries are in use, tags are declined and forwarded with their taken bit unchanged, and no ready flag is cleared.
- R12: While tag_out_valid=1 and tag_out_ready=0, tag_in_ready is 0 and the held output tag does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Type-mask write strobe |
| cfg_node | input | IDX_W | Node whose type mask is written |
| cfg_types | input | TYPES | New type mask, bit t allows type t |
| node_ready_set | input | NODES | One pulse per node that becomes ready |
| node_avail | output | NODES | Current ready flags |
| tag_in_valid | input | 1 | Incoming tag valid |
| tag_in_ready | output | 1 | Incoming tag accepted when high with valid |
| tag_in_type | input | TYPE_W | Event type |
| tag_in_evt | input | EVT_W | Event number |
| tag_in_shadow | input | 1 | Request a shadow copy |
| tag_in_taken | input | 1 | Tag already claimed upstream |
| tag_out_valid | output | 1 | Forwarded tag valid |
| tag_out_ready | input | 1 | Downstream accepts forwarded tag |
| tag_out_type | output | TYPE_W | Forwarded event type |
| tag_out_evt | output | EVT_W | Forwarded event number |
| tag_out_shadow | output | 1 | Forwarded shadow request |
| tag_out_taken | output | 1 | Forwarded taken mark |
| blk_valid | input | 1 | Data block present |
| blk_evt | input | EVT_W | Event number from block header |
| blk_last | input | 1 | Last block of its event |
| blk_data | input | DATA_W | Block payload word |
| node_out_valid | output | NODES | Per-node block strobe |
| node_out_data | output | DATA_W | Routed payload word |
| drop_count | output | DROP_W | Saturating count of dropped blocks |

## Verification
The main vector walk sends tags under several conditions: all nodes ready, only one eligible node, none eligible, shadow requests with two candidates and with one, tags arriving already taken, and types that only a single node accepts. Each claim is followed by a last data block, so the node that was picked is visible at the per-node outputs. This separates a round-robin error from an eligibility error, and a claim error from a forwarding error. Directed sequences then cover multi-block events, reuse after an entry is freed, a full assignment table, a set pulse that coincides with an assignment, and output back-pressure.

// File: rtl/snr_pkg.sv
package snr_pkg;
   typedef enum logic [1:0] {
      CLAIM_NONE = 2'd0,
      CLAIM_ONE  = 2'd1,
      CLAIM_TWO  = 2'd2
   } claim_e;
endpackage

// File: rtl/snr_elig_table.sv
module snr_elig_table #(
   parameter int NODES = 4,
   parameter int TYPES = 8,
   localparam int IDX_W  = $clog2(NODES),
   localparam int TYPE_W = $clog2(TYPES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_node,
   input  logic [TYPES-1:0]  wr_types,
   input  logic [TYPE_W-1:0] look_type,
   output logic [NODES-1:0]  look_elig
);
   for (genvar n = 0; n < NODES; n++) begin : g_node
      logic [TYPES-1:0] types_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            types_q <= '0;
         else if (wr_en && wr_node == IDX_W'(n))
            types_q <= wr_types;
      end
      assign look_elig[n] = types_q[look_type];
   end
endmodule

// File: rtl/snr_ready_pool.sv
module snr_ready_pool #(
   parameter int NODES = 4,
   localparam int IDX_W = $clog2(NODES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NODES-1:0] set_req,
   input  logic [NODES-1:0] elig,
   input  logic             take_one,
   input  logic             take_two,
   output logic [NODES-1:0] avail,
   output logic [NODES-1:0] prim_oh,
   output logic [NODES-1:0] shad_oh,
   output logic             can_one,
   output logic             can_two
);
   logic [NODES-1:0] avail_q;
   logic [IDX_W-1:0] last_q;
   logic [IDX_W-1:0] prim_idx;
   logic [NODES-1:0] cand;
   logic [NODES-1:0] cand2;
   logic [NODES-1:0] clr;

   assign cand = avail_q & elig;

   always_comb begin
      prim_idx = last_q;
      can_one  = 1'b0;
      prim_oh  = '0;
      for (int k = 1; k <= NODES; k++) begin
         int j;
         j = int'(last_q) + k;
         if (j >= NODES) j = j - NODES;
         if (!can_one && cand[j]) begin
            can_one     = 1'b1;
            prim_idx    = IDX_W'(j);
            prim_oh[j]  = 1'b1;
         end
      end
   end

   assign cand2 = cand & ~prim_oh;

   always_comb begin
      can_two = 1'b0;
      shad_oh = '0;
      for (int k = 1; k < NODES; k++) begin
         int j;
         j = int'(prim_idx) + k;
         if (j >= NODES) j = j - NODES;
         if (!can_two && cand2[j]) begin
            can_two    = 1'b1;
            shad_oh[j] = 1'b1;
         end
      end
   end

   always_comb begin
      clr = '0;
      if (take_one) clr = prim_oh;
      if (take_two) clr = prim_oh | shad_oh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         avail_q <= '0;
         last_q  <= IDX_W'(NODES - 1);
      end else begin
         avail_q <= (avail_q | set_req) & ~clr;
         if (take_one || take_two) last_q <= prim_idx;
      end
   end

   assign avail = avail_q;
endmodule

// File: rtl/snr_evt_map.sv
module snr_evt_map #(
   parameter int NODES  = 4,
   parameter int EVT_W  = 8,
   parameter int DEPTH  = 4,
   parameter int DATA_W = 16,
   parameter int DROP_W = 8,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_req,
   input  logic [EVT_W-1:0]  alloc_evt,
   input  logic [NODES-1:0]  alloc_mask,
   output logic              has_free,
   input  logic              blk_valid,
   input  logic [EVT_W-1:0]  blk_evt,
   input  logic              blk_last,
   input  logic [DATA_W-1:0] blk_data,
   output logic [NODES-1:0]  out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [DROP_W-1:0] drops
);
   logic [DEPTH-1:0] ent_v;
   logic [EVT_W-1:0] ent_evt  [DEPTH];
   logic [NODES-1:0] ent_mask [DEPTH];
   logic [AW-1:0]    free_idx;
   logic [AW-1:0]    hit_idx;
   logic             hit;
   logic [NODES-1:0] ov_q;
   logic [DATA_W-1:0] od_q;
   logic [DROP_W-1:0] drop_q;

   always_comb begin
      has_free = 1'b0;
      free_idx = '0;
      hit      = 1'b0;
      hit_idx  = '0;
      for (int e = DEPTH - 1; e >= 0; e--) begin
         if (!ent_v[e]) begin
            has_free = 1'b1;
            free_idx = AW'(e);
         end
         if (ent_v[e] && ent_evt[e] == blk_evt) begin
            hit     = 1'b1;
            hit_idx = AW'(e);
         end
      end
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic             v_q;
      logic [EVT_W-1:0] evt_q;
      logic [NODES-1:0] mask_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q    <= 1'b0;
            evt_q  <= '0;
            mask_q <= '0;
         end else if (alloc_req && has_free && free_idx == AW'(e)) begin
            v_q    <= 1'b1;
            evt_q  <= alloc_evt;
            mask_q <= alloc_mask;
         end else if (blk_valid && blk_last && hit && hit_idx == AW'(e)) begin
            v_q <= 1'b0;
         end
      end
      assign ent_v[e]    = v_q;
      assign ent_evt[e]  = evt_q;
      assign ent_mask[e] = mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov_q   <= '0;
         od_q   <= '0;
         drop_q <= '0;
      end else begin
         ov_q <= '0;
         if (blk_valid) begin
            if (hit) begin
               ov_q <= ent_mask[hit_idx];
               od_q <= blk_data;
            end else if (drop_q != {DROP_W{1'b1}}) begin
               drop_q <= drop_q + 1'b1;
            end
         end
      end
   end

   assign out_valid = ov_q;
   assign out_data  = od_q;
   assign drops     = drop_q;
endmodule

// File: rtl/snr_segment_router.sv
module snr_segment_router
   import snr_pkg::*;
#(
   parameter int NODES     = 4,
   parameter int TYPES     = 8,
   parameter int EVT_W     = 8,
   parameter int DEPTH     = 4,
   parameter int DATA_W    = 16,
   parameter int DROP_W    = 8,
   parameter bit SHADOW_EN = 1'b1,
   localparam int IDX_W  = $clog2(NODES),
   localparam int TYPE_W = $clog2(TYPES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_node,
   input  logic [TYPES-1:0]  cfg_types,
   input  logic [NODES-1:0]  node_ready_set,
   output logic [NODES-1:0]  node_avail,
   input  logic              tag_in_valid,
   output logic              tag_in_ready,
   input  logic [TYPE_W-1:0] tag_in_type,
   input  logic [EVT_W-1:0]  tag_in_evt,
   input  logic              tag_in_shadow,
   input  logic              tag_in_taken,
   output logic              tag_out_valid,
   input  logic              tag_out_ready,
   output logic [TYPE_W-1:0] tag_out_type,
   output logic [EVT_W-1:0]  tag_out_evt,
   output logic              tag_out_shadow,
   output logic              tag_out_taken,
   input  logic              blk_valid,
   input  logic [EVT_W-1:0]  blk_evt,
   input  logic              blk_last,
   input  logic [DATA_W-1:0] blk_data,
   output logic [NODES-1:0]  node_out_valid,
   output logic [DATA_W-1:0] node_out_data,
   output logic [DROP_W-1:0] drop_count
);
   if (NODES < 2) begin : g_bad_nodes
      $error("snr_segment_router: NODES must be at least 2");
   end
   if (TYPES < 2) begin : g_bad_types
      $error("snr_segment_router: TYPES must be at least 2");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("snr_segment_router: DEPTH must be at least 1");
   end

   logic [NODES-1:0] elig;
   logic [NODES-1:0] prim_oh, shad_oh;
   logic             can_one, can_two, has_free;
   logic             want_pair, accept;
   claim_e           claim;
   logic [NODES-1:0] alloc_mask;

   if (SHADOW_EN) begin : g_shadow
      assign want_pair = tag_in_shadow;
   end else begin : g_single
      assign want_pair = 1'b0;
   end

   assign tag_in_ready = !tag_out_valid || tag_out_ready;
   assign accept       = tag_in_valid && tag_in_ready;

   always_comb begin
      claim = CLAIM_NONE;
      if (accept && !tag_in_taken && has_free) begin
         if (want_pair) begin
            if (can_two) claim = CLAIM_TWO;
         end else if (can_one) begin
            claim = CLAIM_ONE;
         end
      end
   end

   assign alloc_mask = (claim == CLAIM_TWO) ? (prim_oh | shad_oh) : prim_oh;

   snr_elig_table #(.NODES(NODES), .TYPES(TYPES)) u_elig (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_node   (cfg_node),
      .wr_types  (cfg_types),
      .look_type (tag_in_type),
      .look_elig (elig)
   );

   snr_ready_pool #(.NODES(NODES)) u_pool (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_req  (node_ready_set),
      .elig     (elig),
      .take_one (claim == CLAIM_ONE),
      .take_two (claim == CLAIM_TWO),
      .avail    (node_avail),
      .prim_oh  (prim_oh),
      .shad_oh  (shad_oh),
      .can_one  (can_one),
      .can_two  (can_two)
   );

   snr_evt_map #(
      .NODES(NODES), .EVT_W(EVT_W), .DEPTH(DEPTH),
      .DATA_W(DATA_W), .DROP_W(DROP_W)
   ) u_map (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_req  (claim != CLAIM_NONE),
      .alloc_evt  (tag_in_evt),
      .alloc_mask (alloc_mask),
      .has_free   (has_free),
      .blk_valid  (blk_valid),
      .blk_evt    (blk_evt),
      .blk_last   (blk_last),
      .blk_data   (blk_data),
      .out_valid  (node_out_valid),
      .out_data   (node_out_data),
      .drops      (drop_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_out_valid  <= 1'b0;
         tag_out_type   <= '0;
         tag_out_evt    <= '0;
         tag_out_shadow <= 1'b0;
         tag_out_taken  <= 1'b0;
      end else if (accept) begin
         tag_out_valid  <= 1'b1;
         tag_out_type   <= tag_in_type;
         tag_out_evt    <= tag_in_evt;
         tag_out_shadow <= tag_in_shadow;
         tag_out_taken  <= tag_in_taken || (claim != CLAIM_NONE);
      end else if (tag_out_ready) begin
         tag_out_valid  <= 1'b0;
      end
   end
endmodule

// File: rtl/snr_router_chk.sv
module snr_router_chk #(
   parameter int NODES  = 4,
   parameter int EVT_W  = 8,
   parameter int DROP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NODES-1:0]  node_avail,
   input logic              tag_in_valid,
   input logic              tag_in_ready,
   input logic [EVT_W-1:0]  tag_in_evt,
   input logic              tag_in_taken,
   input logic              tag_out_valid,
   input logic              tag_out_ready,
   input logic [EVT_W-1:0]  tag_out_evt,
   input logic              tag_out_taken,
   input logic [NODES-1:0]  node_out_valid,
   input logic [DROP_W-1:0] drop_count
);
   // R12
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_out_valid && !tag_out_ready) |=> (tag_out_valid && $stable(tag_out_evt)));

   // R12
   in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_out_valid && !tag_out_ready) |-> !tag_in_ready);

   // R6
   fwd_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_in_valid && tag_in_ready) |=> (tag_out_valid && tag_out_evt == $past(tag_in_evt)));

   // R7
   taken_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_in_valid && tag_in_ready && tag_in_taken) |=> tag_out_taken);

   // R7
   taken_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_in_valid && tag_in_ready && tag_in_taken)
         |=> ((node_avail & $past(node_avail)) == $past(node_avail)));

   // R10
   drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (drop_count >= $past(drop_count)));

   // R5
   fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(node_out_valid) <= 2);
endmodule

bind snr_segment_router snr_router_chk #(
   .NODES(NODES), .EVT_W(EVT_W), .DROP_W(DROP_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .node_avail     (node_avail),
   .tag_in_valid   (tag_in_valid),
   .tag_in_ready   (tag_in_ready),
   .tag_in_evt     (tag_in_evt),
   .tag_in_taken   (tag_in_taken),
   .tag_out_valid  (tag_out_valid),
   .tag_out_ready  (tag_out_ready),
   .tag_out_evt    (tag_out_evt),
   .tag_out_taken  (tag_out_taken),
   .node_out_valid (node_out_valid),
   .drop_count     (drop_count)
);

// File: tb/tb_snr_segment_router.sv
module tb_snr_segment_router;
   localparam int NODES = 4, TYPES = 8, EVT_W = 8, DEPTH = 4, DATA_W = 16, DROP_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_node = '0;
   logic [TYPES-1:0] cfg_types = '0;
   logic [NODES-1:0] node_ready_set = '0;
   logic [NODES-1:0] node_avail;
   logic tag_in_valid = 1'b0;
   logic tag_in_ready;
   logic [2:0] tag_in_type = '0;
   logic [EVT_W-1:0] tag_in_evt = '0;
   logic tag_in_shadow = 1'b0;
   logic tag_in_taken = 1'b0;
   logic tag_out_valid;
   logic tag_out_ready = 1'b1;
   logic [2:0] tag_out_type;
   logic [EVT_W-1:0] tag_out_evt;
   logic tag_out_shadow, tag_out_taken;
   logic blk_valid = 1'b0;
   logic [EVT_W-1:0] blk_evt = '0;
   logic blk_last = 1'b0;
   logic [DATA_W-1:0] blk_data = '0;
   logic [NODES-1:0] node_out_valid;
   logic [DATA_W-1:0] node_out_data;
   logic [DROP_W-1:0] drop_count;

   always #5 clk = ~clk;

   snr_segment_router dut (.*);

   int n_checks = 0;
   int n_fail = 0;
   int exp_drop = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_cfg(input int node, input logic [TYPES-1:0] types);
      @(negedge clk);
      cfg_we = 1'b1; cfg_node = 2'(node); cfg_types = types;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_ready(input logic [NODES-1:0] m);
      @(negedge clk);
      node_ready_set = m;
      @(negedge clk);
      node_ready_set = '0;
   endtask

   // drives one tag, returns after the output register has taken it
   task automatic send_tag(input logic [2:0] typ, input logic [7:0] evt, input bit shd,
                           input bit tkn, input logic [NODES-1:0] setr);
      @(negedge clk);
      tag_in_valid = 1'b1; tag_in_type = typ; tag_in_evt = evt;
      tag_in_shadow = shd; tag_in_taken = tkn; node_ready_set = setr;
      @(posedge clk); #1;
      @(negedge clk);
      tag_in_valid = 1'b0; node_ready_set = '0;
   endtask

   task automatic send_blk(input logic [7:0] evt, input bit last, input logic [15:0] d);
      @(negedge clk);
      blk_valid = 1'b1; blk_evt = evt; blk_last = last; blk_data = d;
      @(posedge clk); #1;
   endtask

   task automatic end_blk();
      @(negedge clk);
      blk_valid = 1'b0; blk_last = 1'b0;
   endtask

   typedef struct packed {
      logic [3:0] setr;
      logic [2:0] typ;
      logic [7:0] evt;
      logic       shd;
      logic       tkn;
      logic       exp_tkn;
      logic [3:0] exp_mask;
      logic [3:0] exp_avail;
   } vec_t;

   localparam vec_t VEC [9] = '{
      '{4'b1111, 3'd0, 8'd10, 1'b0, 1'b0, 1'b1, 4'b0001, 4'b1110},
      '{4'b0000, 3'd0, 8'd11, 1'b0, 1'b0, 1'b1, 4'b0010, 4'b1100},
      '{4'b0000, 3'd0, 8'd12, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b1100},
      '{4'b0011, 3'd1, 8'd13, 1'b1, 1'b0, 1'b1, 4'b0101, 4'b1010},
      '{4'b0000, 3'd1, 8'd14, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b1010},
      '{4'b0000, 3'd3, 8'd15, 1'b0, 1'b1, 1'b1, 4'b0000, 4'b1010},
      '{4'b0101, 3'd1, 8'd16, 1'b0, 1'b0, 1'b1, 4'b0001, 4'b1110},
      '{4'b0000, 3'd3, 8'd17, 1'b0, 1'b0, 1'b1, 4'b1000, 4'b0110},
      '{4'b1001, 3'd2, 8'd18, 1'b0, 1'b0, 1'b1, 4'b0100, 4'b1011}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 during reset
      check(tag_out_valid == 0 && node_out_valid == 0, "R1", {tag_out_valid, node_out_valid}, 0);
      check(node_avail == 0 && drop_count == 0, "R1", {node_avail, drop_count}, 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check(node_avail == 0 && tag_out_valid == 0, "R1", {node_avail, tag_out_valid}, 0);

      // R2 type masks: nodes 0,1 take types 0-1, node 2 types 1-2, node 3 type 3
      write_cfg(0, 8'h03);
      write_cfg(1, 8'h03);
      write_cfg(2, 8'h06);
      write_cfg(3, 8'h08);

      // Vector walk: R2 R3 R4 R5 R6 R7 R8 R10
      foreach (VEC[i]) begin
         if (VEC[i].setr != 0) pulse_ready(VEC[i].setr);
         @(negedge clk);
         tag_in_valid = 1'b1; tag_in_type = VEC[i].typ; tag_in_evt = VEC[i].evt;
         tag_in_shadow = VEC[i].shd; tag_in_taken = VEC[i].tkn;
         @(posedge clk); #1;
         check(tag_out_valid && tag_out_taken == VEC[i].exp_tkn, "R6", tag_out_taken, VEC[i].exp_tkn);
         check(tag_out_evt == VEC[i].evt && tag_out_type == VEC[i].typ && tag_out_shadow == VEC[i].shd,
               "R6", tag_out_evt, VEC[i].evt);
         check(node_avail == VEC[i].exp_avail, "R3/R4/R5 avail", node_avail, VEC[i].exp_avail);
         @(negedge clk); tag_in_valid = 1'b0;
         send_blk(VEC[i].evt, 1'b1, 16'(VEC[i].evt) * 16'd3);
         check(node_out_valid == VEC[i].exp_mask, "R2/R3/R5/R8 mask", node_out_valid, VEC[i].exp_mask);
         if (VEC[i].exp_mask != 0)
            check(node_out_data == 16'(VEC[i].evt) * 16'd3, "R8", node_out_data, VEC[i].evt * 3);
         else
            exp_drop++;
         end_blk();
         check(drop_count == DROP_W'(exp_drop), "R10", drop_count, exp_drop);
      end

      // R9: multi-block event, then reuse after free (claims node 0)
      send_tag(3'd0, 8'd20, 1'b0, 1'b0, 4'b0000);
      check(tag_out_taken == 1'b1, "R9 claim", tag_out_taken, 1);
      send_blk(8'd20, 1'b0, 16'h1111);
      check(node_out_valid == 4'b0001, "R9 first", node_out_valid, 1);
      send_blk(8'd20, 1'b1, 16'h2222);
      check(node_out_valid == 4'b0001 && node_out_data == 16'h2222, "R9 last", node_out_valid, 1);
      send_blk(8'd20, 1'b1, 16'h3333);
      check(node_out_valid == 4'b0000, "R9 freed", node_out_valid, 0);
      end_blk();
      exp_drop++;
      check(drop_count == DROP_W'(exp_drop), "R10", drop_count, exp_drop);

      // R11: fill all entries, then a tag must be declined
      write_cfg(3, 8'hFF);
      pulse_ready(4'b1111);
      for (int k = 0; k < DEPTH; k++) send_tag(3'd1, 8'(30 + k), 1'b0, 1'b0, 4'b0000);
      check(node_avail == 4'b0000, "R11 filled", node_avail, 0);
      pulse_ready(4'b1111);
      send_tag(3'd1, 8'd34, 1'b0, 1'b0, 4'b0000);
      check(tag_out_taken == 1'b0, "R11 decline", tag_out_taken, 0);
      check(node_avail == 4'b1111, "R11 avail", node_avail, 4'hF);
      for (int k = 0; k < DEPTH; k++) begin
         send_blk(8'(30 + k), 1'b1, 16'(k));
         check(node_out_valid != 0, "R11 route", node_out_valid, 1);
      end
      end_blk();

      // R4: set pulse in the cycle its node is chosen (node 1) is ignored
      send_tag(3'd1, 8'd35, 1'b0, 1'b0, 4'b0010);
      check(tag_out_taken == 1'b1, "R4 claim", tag_out_taken, 1);
      check(node_avail == 4'b1101, "R4 same-cycle set", node_avail, 4'hD);

      // R12: back-pressure holds the output tag
      @(negedge clk);
      tag_out_ready = 1'b0;
      tag_in_valid = 1'b1; tag_in_evt = 8'd40; tag_in_taken = 1'b1; tag_in_shadow = 1'b0;
      @(posedge clk); #1;
      check(tag_out_valid && tag_out_evt == 8'd40, "R12 load", tag_out_evt, 40);
      check(tag_in_ready == 1'b0, "R12 stall", tag_in_ready, 0);
      @(negedge clk);
      tag_in_evt = 8'd41;
      @(posedge clk); #1;
      check(tag_out_evt == 8'd40, "R12 hold", tag_out_evt, 40);
      @(negedge clk);
      tag_out_ready = 1'b1;
      @(posedge clk); #1;
      check(tag_out_evt == 8'd41, "R12 release", tag_out_evt, 41);
      check(node_avail == 4'b1101, "R7 no change", node_avail, 4'hD);
      @(negedge clk);
      tag_in_valid = 1'b0; tag_in_taken = 1'b0;
      @(posedge clk); #1;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule